// File: doc/BRIEF.md
# Triggered Conversion Slot Sequencer

This block decides which analog conversion runs next. It has a set of conversion slots. Each slot stores a channel number, a trigger source code and a sample-window length. A slot becomes pending when one of three things happens: the external trigger line it selects pulses, software writes a 1 to its bit in the force register, or the block's own interrupt pulse fires while the slot's re-trigger mask bit is set. Pending slots are handed out one at a time, in rotating order, to an external conversion engine. For each granted slot, the block first holds `samp_hold` high for the sample window. It then raises `conv_req` and waits for `conv_done`, which carries a 12-bit result.

Each result is kept in a register belonging to its slot. A single interrupt source watches the completion of one chosen slot. It can behave in two ways: it waits until software clears its flag before pulsing again, or it pulses on every completion. Setting re-trigger mask bits makes slots loop on their own, which gives free-running conversion. All setup goes through a simple write port. Results are read through a combinational slot-indexed read port.

Top module: `conv_sequencer`

## Requirements
- R1: A write to address s (0..15) configures slot s. The data bits are: channel in [3:0], trigger code in [8:4], window value in [14:9]. While slot s is sampled and converted, `conv_chan` shows its channel.
- R2: After a grant, `samp_hold` stays high for exactly window+1 cycles, and then `conv_req` rises. A window value below 6 is stored as 6.
- R3: A nonzero trigger code k makes a pulse on `ext_trig[k]` trigger the slot. Code 5 is the start pulse from PWM unit 1, and code 0 selects no external line. A write to address 18 triggers every slot whose data bit is 1.
- R4: Only one slot is sampled or converted at a time. Among pending slots, the grant goes to the first one found searching upward (wrapping) from the slot after the one that finished most recently. Slot 0 goes first after reset.
- R5: A trigger for a slot that is already pending sets that slot's bit in `ovf_flags` and starts no second conversion. Writing 1s to address 19 clears the matching bits.
- R6: When `conv_done` is seen, `conv_result` is stored in the result register of the finishing slot. `rd_result` shows the register selected by `rd_slot`.
- R7: Address 20 bits [4:0] select the slot that drives the interrupt. The interrupt can only pulse when this value is below 15.
- R8: When address 20 bit 5 is 0, a completion of the selected slot sets `int_flag`. It pulses `int_pulse` only if the flag was clear. Writing address 21 with bit 0 set clears the flag.
- R9: When address 20 bit 5 is 1, every completion of the selected slot pulses `int_pulse`, whatever the flag holds.
- R10: When address 20 bit 6 is 1, `int_pulse` is high in the cycle before the new result appears on `rd_result`. When bit 6 is 0, it is high in the first cycle the new result appears.
- R11: Address 17 holds a re-trigger mask. A masked slot is triggered by `int_pulse`, and its external trigger code is ignored.
- R12: After reset, `samp_hold`, `conv_req`, `int_pulse`, `int_flag` and `ovf_flags` are 0, and all results read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 5 | register write address |
| wr_data | input | 16 | register write data |
| ext_trig | input | 32 | external trigger pulse lines, indexed by trigger code |
| samp_hold | output | 1 | sample window active for the granted slot |
| conv_req | output | 1 | conversion request to the engine |
| conv_chan | output | 4 | channel of the granted slot |
| conv_done | input | 1 | engine completion strobe |
| conv_result | input | 12 | engine result, valid with conv_done |
| rd_slot | input | 4 | result read select |
| rd_result | output | 12 | stored result of the selected slot |
| int_pulse | output | 1 | interrupt pulse |
| int_flag | output | 1 | interrupt flag |
| ovf_flags | output | 16 | per-slot trigger overflow flags |

## Verification
The rotating grant is tested with two multi-slot force patterns whose expected order differs from a fixed-priority order. This shows that the search starts from the slot that finished last. Triggers are applied through each path in turn: the selected external line, an unselected line, the force register, and the interrupt through the mask. This separates correct source routing from a masked slot that still listens to its external line. The interrupt is driven through flag-wait, continuous and disabled selections, and in both pulse positions. The distance between `conv_done` and `int_pulse`, together with the value on `rd_result` at the pulse, tells the early placement from the late one.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  parameter int CH_W   = 4;
  parameter int TSEL_W = 5;
  parameter int WIN_W  = 6;

  typedef struct packed {
    logic [WIN_W-1:0]  win;
    logic [TSEL_W-1:0] trig;
    logic [CH_W-1:0]   chan;
  } slot_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONVERT} seq_state_e;
endpackage

// File: rtl/seq_rr_pick.sv
module seq_rr_pick #(
  parameter int N      = 16,
  parameter int SLOT_W = $clog2(N)
) (
  input  logic [N-1:0]      req,
  input  logic [SLOT_W-1:0] last,
  output logic              vld,
  output logic [SLOT_W-1:0] idx
);
  logic [SLOT_W-1:0] cand;

  always_comb begin
    vld  = 1'b0;
    idx  = '0;
    cand = '0;
    for (int i = 1; i <= N; i++) begin
      cand = SLOT_W'((int'(last) + i) % N);
      if (!vld && req[cand]) begin
        vld = 1'b1;
        idx = cand;
      end
    end
  end
endmodule

// File: rtl/seq_irq.sv
module seq_irq #(
  parameter int SLOT_W = 4,
  parameter int SEL_W  = 5,
  parameter int LIMIT  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_evt,
  input  logic [SLOT_W-1:0] done_slot,
  input  logic [SEL_W-1:0]  int_sel,
  input  logic              cont_mode,
  input  logic              early,
  input  logic              flag_clr,
  output logic              int_pulse,
  output logic              int_flag
);
  logic hit, fire, flag_d, flag_q, pulse_a_q, pulse_b_q;

  always_comb begin
    hit    = done_evt && (int_sel < SEL_W'(LIMIT)) && (int_sel == SEL_W'(done_slot));
    fire   = hit && (cont_mode || !flag_q);
    flag_d = hit ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      pulse_a_q <= 1'b0;
      pulse_b_q <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      pulse_a_q <= fire;
      pulse_b_q <= pulse_a_q;
    end
  end

  assign int_pulse = early ? pulse_a_q : pulse_b_q;
  assign int_flag  = flag_q;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int RES_W     = 12,
  parameter int DATA_W    = 16,
  parameter int MIN_WIN   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NUM_SLOTS):0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [(1<<TSEL_W)-1:0]   ext_trig,
  output logic                     samp_hold,
  output logic                     conv_req,
  output logic [CH_W-1:0]          conv_chan,
  input  logic                     conv_done,
  input  logic [RES_W-1:0]         conv_result,
  input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot,
  output logic [RES_W-1:0]         rd_result,
  output logic                     int_pulse,
  output logic                     int_flag,
  output logic [NUM_SLOTS-1:0]     ovf_flags
);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ADDR_W    = SLOT_W + 1;
  localparam int CFG_BITS  = $bits(slot_cfg_t);
  localparam int A_MASK    = NUM_SLOTS + 1;
  localparam int A_FORCE   = NUM_SLOTS + 2;
  localparam int A_OVFCLR  = NUM_SLOTS + 3;
  localparam int A_INTCTL  = NUM_SLOTS + 4;
  localparam int A_FLAGCLR = NUM_SLOTS + 5;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  // configuration storage
  slot_cfg_t          cfg_q [NUM_SLOTS];
  slot_cfg_t          cfg_wr;
  logic [NUM_SLOTS-1:0] mask_q;
  logic [ADDR_W-1:0]  int_sel_q;
  logic               cont_q, early_q;

  always_comb begin
    cfg_wr = slot_cfg_t'(wr_data[CFG_BITS-1:0]);
    if (cfg_wr.win < WIN_W'(MIN_WIN)) cfg_wr.win = WIN_W'(MIN_WIN);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) cfg_q[i] <= '{win: WIN_W'(MIN_WIN), trig: '0, chan: '0};
      mask_q    <= '0;
      int_sel_q <= '1;
      cont_q    <= 1'b0;
      early_q   <= 1'b0;
    end else if (wr_en) begin
      if (!wr_addr[ADDR_W-1]) cfg_q[wr_addr[SLOT_W-1:0]] <= cfg_wr;
      if (wr_addr == ADDR_W'(A_MASK)) mask_q <= wr_data[NUM_SLOTS-1:0];
      if (wr_addr == ADDR_W'(A_INTCTL)) begin
        int_sel_q <= wr_data[ADDR_W-1:0];
        cont_q    <= wr_data[ADDR_W];
        early_q   <= wr_data[ADDR_W+1];
      end
    end
  end

  // trigger gathering
  logic [NUM_SLOTS-1:0] trig, force_vec, ovf_clr;
  assign force_vec = (wr_en && wr_addr == ADDR_W'(A_FORCE))  ? wr_data[NUM_SLOTS-1:0] : '0;
  assign ovf_clr   = (wr_en && wr_addr == ADDR_W'(A_OVFCLR)) ? wr_data[NUM_SLOTS-1:0] : '0;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_trig
    logic ext_hit;
    assign ext_hit = (cfg_q[g].trig != '0) && ext_trig[cfg_q[g].trig];
    assign trig[g] = (mask_q[g] ? int_pulse : ext_hit) | force_vec[g];
  end

  // pending set and arbitration
  logic [NUM_SLOTS-1:0] pend_q, pend_d, ovf_q, ovf_d, grant;
  logic                 pick_vld;
  logic [SLOT_W-1:0]    pick_idx, last_q, last_d, act_q, act_d;
  seq_state_e           state_q, state_d;
  logic [WIN_W-1:0]     cnt_q, cnt_d;
  logic                 finish;

  seq_rr_pick #(.N(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .req(pend_q), .last(last_q), .vld(pick_vld), .idx(pick_idx)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    last_d  = last_q;
    grant   = '0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: if (pick_vld) begin
        grant[pick_idx] = 1'b1;
        act_d   = pick_idx;
        cnt_d   = '0;
        state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (cnt_q == cfg_q[act_q].win) state_d = ST_CONVERT;
        else                           cnt_d   = cnt_q + 1'b1;
      end
      ST_CONVERT: if (conv_done) begin
        finish  = 1'b1;
        last_d  = act_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    pend_d = (pend_q & ~grant) | trig;
    ovf_d  = (ovf_q & ~ovf_clr) | (trig & pend_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      last_q  <= SLOT_W'(NUM_SLOTS - 1);
      pend_q  <= '0;
      ovf_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      last_q  <= last_d;
      pend_q  <= pend_d;
      ovf_q   <= ovf_d;
    end
  end

  // result staging, then per-slot store
  logic              stg_vld_q;
  logic [SLOT_W-1:0] stg_slot_q;
  logic [RES_W-1:0]  stg_data_q;
  logic [RES_W-1:0]  res_q [NUM_SLOTS];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      stg_vld_q  <= 1'b0;
      stg_slot_q <= '0;
      stg_data_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) res_q[i] <= '0;
    end else begin
      stg_vld_q <= finish;
      if (finish) begin
        stg_slot_q <= act_q;
        stg_data_q <= conv_result;
      end
      if (stg_vld_q) res_q[stg_slot_q] <= stg_data_q;
    end
  end

  seq_irq #(.SLOT_W(SLOT_W), .SEL_W(ADDR_W), .LIMIT(NUM_SLOTS - 1)) u_irq (
    .clk(clk), .rst_n(srst_n), .done_evt(finish), .done_slot(act_q),
    .int_sel(int_sel_q), .cont_mode(cont_q), .early(early_q),
    .flag_clr(wr_en && wr_addr == ADDR_W'(A_FLAGCLR) && wr_data[0]),
    .int_pulse(int_pulse), .int_flag(int_flag)
  );

  assign samp_hold = (state_q == ST_SAMPLE);
  assign conv_req  = (state_q == ST_CONVERT);
  assign conv_chan = cfg_q[act_q].chan;
  assign rd_result = res_q[rd_slot];
  assign ovf_flags = ovf_q;
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int NUM_SLOTS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 samp_hold,
  input logic                 conv_req,
  input logic                 conv_done,
  input logic                 int_pulse,
  input logic [NUM_SLOTS-1:0] ovf_flags
);
  assert_min_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_hold) |-> ($past(samp_hold, 2) && $past(samp_hold, 7)));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> conv_req);

  assert_req_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(samp_hold));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

  assert_pulse_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |-> ($past(conv_done) || $past(conv_done, 2)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |=> !int_pulse);
endmodule

bind conv_sequencer conv_sequencer_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .samp_hold(samp_hold),
  .conv_req(conv_req), .conv_done(conv_done), .int_pulse(int_pulse),
  .ovf_flags(ovf_flags)
);

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic [31:0] ext_trig;
  logic        samp_hold, conv_req, conv_done, int_pulse, int_flag;
  logic [3:0]  conv_chan, rd_slot;
  logic [11:0] conv_result, rd_result;
  logic [15:0] ovf_flags;

  conv_sequencer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_trig(ext_trig), .samp_hold(samp_hold), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
    .rd_slot(rd_slot), .rd_result(rd_result), .int_pulse(int_pulse),
    .int_flag(int_flag), .ovf_flags(ovf_flags)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int run = 0, last_width = 0;
  int log_chan [0:255];
  int log_n = 0;
  int pulse_cnt = 0, pulse_cyc = 0, done_cyc = 0, pulse_res = 0;
  logic prev_req = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(input logic [3:0] ch);
    return int'(ch) * 256 + 60;
  endfunction

  // engine model: done two edges after request seen
  initial begin
    conv_done = 1'b0;
    conv_result = '0;
    forever begin
      @(negedge clk);
      if (conv_req) begin
        @(posedge clk);
        @(posedge clk);
        #1 conv_done = 1'b1;
        conv_result = 12'(model(conv_chan));
        @(posedge clk);
        #1 conv_done = 1'b0;
      end
    end
  end

  // observation at negedge
  always @(negedge clk) begin
    if (samp_hold) run <= run + 1;
    else if (run != 0) begin
      last_width <= run;
      run <= 0;
    end
    if (conv_req && !prev_req) begin
      log_chan[log_n] <= int'(conv_chan);
      log_n <= log_n + 1;
    end
    prev_req <= conv_req;
    if (conv_done) done_cyc <= cyc;
    if (int_pulse) begin
      pulse_cnt <= pulse_cnt + 1;
      pulse_cyc <= cyc;
      pulse_res <= int'(rd_result);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] cfgw(input int ch, input int tr, input int w);
    return {1'b0, 6'(w), 5'(tr), 4'(ch)};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ext(input int k);
    @(negedge clk);
    ext_trig[k] = 1'b1;
    @(negedge clk);
    ext_trig = '0;
  endtask

  function automatic int count_chan(input int ch, input int from);
    int c = 0;
    for (int i = from; i < log_n; i++) if (log_chan[i] == ch) c++;
    return c;
  endfunction

  task automatic t_reset();
    check("R12 samp_hold", int'(samp_hold), 0);
    check("R12 conv_req", int'(conv_req), 0);
    check("R12 int_pulse", int'(int_pulse), 0);
    check("R12 int_flag", int'(int_flag), 0);
    check("R12 ovf_flags", int'(ovf_flags), 0);
    check("R12 result", int'(rd_result), 0);
  endtask

  task automatic t_window();
    wr(5'd2, cfgw(9, 0, 10));
    wr(5'd18, 16'h0004);
    idle(40);
    check("R2 window 10", last_width, 11);
    check("R1 channel", log_chan[log_n-1], 9);
    rd_slot = 4'd2;
    #1 check("R6 result slot2", int'(rd_result), model(4'd9));
    wr(5'd2, cfgw(9, 0, 3));
    wr(5'd18, 16'h0004);
    idle(40);
    check("R2 clamp to 6", last_width, 7);
  endtask

  task automatic t_trig();
    int base;
    wr(5'd3, cfgw(5, 5, 6));
    wr(5'd4, cfgw(6, 7, 6));
    base = log_n;
    pulse_ext(5);
    idle(40);
    check("R3 code5 count", log_n - base, 1);
    check("R3 code5 chan", log_chan[log_n-1], 5);
    pulse_ext(7);
    idle(40);
    check("R3 code7 chan", log_chan[log_n-1], 6);
    pulse_ext(9);
    idle(30);
    check("R3 unselected line", log_n - base, 2);
  endtask

  task automatic t_rr();
    int base;
    wr(5'd0, cfgw(0, 0, 6));
    wr(5'd1, cfgw(1, 0, 6));
    wr(5'd2, cfgw(2, 0, 6));
    wr(5'd5, cfgw(5, 0, 6));
    base = log_n;
    wr(5'd18, 16'h0027);
    idle(90);
    check("R4 rr count", log_n - base, 4);
    check("R4 rr first", log_chan[base], 5);
    check("R4 rr second", log_chan[base+1], 0);
    check("R4 rr fourth", log_chan[base+3], 2);
    base = log_n;
    wr(5'd18, 16'h0026);
    idle(70);
    check("R4 rr2 first", log_chan[base], 5);
    check("R4 rr2 second", log_chan[base+1], 1);
  endtask

  task automatic t_ovf();
    int base;
    wr(5'd6, cfgw(6, 0, 6));
    base = log_n;
    wr(5'd18, 16'h0060);
    wr(5'd18, 16'h0040);
    idle(60);
    check("R5 ovf flag", int'(ovf_flags), 16'h0040);
    check("R5 no second conversion", count_chan(6, base), 1);
    wr(5'd19, 16'h0040);
    check("R5 ovf clear", int'(ovf_flags), 0);
  endtask

  task automatic t_int_wait();
    int p0;
    wr(5'd20, 16'h0003);
    wr(5'd21, 16'h0001);
    p0 = pulse_cnt;
    wr(5'd18, 16'h0008);
    idle(30);
    check("R8 first pulse", pulse_cnt - p0, 1);
    check("R8 flag set", int'(int_flag), 1);
    wr(5'd18, 16'h0008);
    idle(30);
    check("R8 held by flag", pulse_cnt - p0, 1);
    wr(5'd21, 16'h0001);
    check("R8 flag cleared", int'(int_flag), 0);
    wr(5'd18, 16'h0008);
    idle(30);
    check("R8 after clear", pulse_cnt - p0, 2);
  endtask

  task automatic t_int_cont();
    int p0;
    wr(5'd20, 16'h0023);
    p0 = pulse_cnt;
    wr(5'd18, 16'h0008);
    idle(30);
    wr(5'd18, 16'h0008);
    idle(30);
    check("R9 every completion", pulse_cnt - p0, 2);
  endtask

  task automatic t_int_off();
    int p0, base;
    wr(5'd20, 16'h002F);
    p0 = pulse_cnt;
    base = log_n;
    wr(5'd18, 16'h8000);
    idle(30);
    check("R7 slot15 converted", log_n - base, 1);
    check("R7 sel15 no pulse", pulse_cnt - p0, 0);
  endtask

  task automatic t_position();
    wr(5'd7, cfgw(11, 0, 6));
    wr(5'd20, 16'h0067);
    rd_slot = 4'd7;
    wr(5'd18, 16'h0080);
    idle(30);
    check("R10 early distance", pulse_cyc - done_cyc, 1);
    check("R10 early old result", pulse_res, 0);
    wr(5'd7, cfgw(12, 0, 6));
    wr(5'd20, 16'h0027);
    wr(5'd18, 16'h0080);
    idle(30);
    check("R10 late distance", pulse_cyc - done_cyc, 2);
    check("R10 late new result", pulse_res, model(4'd12));
  endtask

  task automatic t_mask();
    int base, snap;
    wr(5'd9, cfgw(13, 5, 6));
    wr(5'd17, 16'h0200);
    wr(5'd20, 16'h0029);
    base = log_n;
    pulse_ext(5);
    idle(40);
    check("R11 ext ignored when masked", count_chan(13, base), 0);
    check("R11 unmasked slot on same line", count_chan(5, base), 1);
    base = log_n;
    wr(5'd18, 16'h0200);
    idle(100);
    check("R11 self re-trigger", int'(count_chan(13, base) >= 4), 1);
    wr(5'd17, 16'h0000);
    idle(60);
    snap = log_n;
    idle(60);
    check("R11 stops when unmasked", log_n, snap);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ext_trig = '0; rd_slot = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_window();
    t_trig();
    t_rr();
    t_ovf();
    t_int_wait();
    t_int_cont();
    t_int_off();
    t_position();
    t_mask();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule